// File: doc/BRIEF.md
# Software Flow Controller for a Serial Port

This block sits between a serial receiver, a serial transmitter and their byte queues, and handles in-band start/stop flow control. Four programmable characters form two pairs, each with a resume character and a stop character. A 4-bit mode word selects which pair the receive path looks for and which pair the transmit path sends. The receive path inspects every byte the deserializer delivers. It removes flow-control characters from the stream and passes every other byte on to the receive queue. Each recognised stop or resume character moves a three-state pause machine, and the transmitter honours that pause.

The transmit path feeds the serializer. When the local receive queue fills to its trigger level, it sends a stop character (or both stop characters of a pair). Once the queue has drained below half of that level, it sends the resume character or characters. These characters go out ahead of queued data, and they go out even while the transmitter is paused. A trigger unit turns the two 8-bit level settings into effective thresholds. It raises an interrupt request and a DMA request for each direction.

Receive matcher states: `M_IDLE` (classify the next byte), `M_HOLD_ON` and `M_HOLD_OFF` (first character of a two-byte sequence held back), `M_FLUSH` (second byte of a broken sequence being written). Its transitions are: idle to a hold state on a first character, hold to idle on the matching second character, hold to flush on any other byte, and flush to idle unconditionally. Pause states: `P_RUN`, `P_DRAIN` (stop recognised, waiting for the serializer to go idle), `P_HOLD` (paused). Transitions: run to drain on a stop character, drain to hold when the serializer is ready, drain or hold to run on a resume character, and any state to run when receive matching is off. Transmit states: `T_DATA` (choose a flow character or queued data) and `T_SECOND` (send the second character of a pair). The transitions are data to second when both characters of a pair are sent, and second to data once that character is loaded.

Top module: `swfc_ctrl`

## Requirements
- R1: With receive matching off (mode[1:0] = 00) every received byte is written to the receive queue, unchanged, in the cycle after `rx_vld`. Received bytes must be at least two cycles apart.
- R2: With mode[1:0] = 10 only `xon1_chr`/`xoff1_chr` are recognised and consumed; with 01 only `xon2_chr`/`xoff2_chr`; the characters of the other pair pass through as data.
- R3: With mode[1:0] = 11 and mode[3:2] not 11, a resume character of either pair and a stop character of either pair are recognised and consumed. This holds whether the transmitter sends pair 1, pair 2 or nothing.
- R4: With mode = 1111 only the sequences `xoff1_chr` then `xoff2_chr`, and `xon1_chr` then `xon2_chr`, are recognised, and both bytes of a sequence are consumed.
- R5: In sequence mode, if the byte after a held first character is not the expected second one, the held byte and then that byte are written as data and the matcher returns to idle. The byte that broke the sequence is never taken as the start of a new one.
- R6: A recognised stop character raises `tx_pause` once `ser_ready` is high. A recognised resume character clears it. Repeating either character in the state it selects changes nothing, and turning receive matching off clears the pause. From two cycles after a stop byte is presented until the resume, no queued byte is loaded.
- R7: When `rxf_count` reaches the effective receive level, the stop character is sent once: `xoff1_chr` for mode[3:2] = 10, `xoff2_chr` for 01, `xoff1_chr` then `xoff2_chr` on consecutive loads for 11, and nothing for 00.
- R8: After a stop has been sent, the resume character(s) are sent once, in the same pair pattern, when `rxf_count` falls below half the effective receive level, rounded down.
- R9: Flow characters are loaded before any queued byte that is waiting at the same moment, and they are loaded even while `tx_pause` is high.
- R10: A level setting of 0x00 or 0x01 means 1, 0x02 to 0x80 mean that value, and any setting above 0x80 means 128.
- R11: `rx_irq` and `rx_dma` are high in the cycle after `rxf_count` is at or above the effective receive level. `tx_irq` and `tx_dma` are high in the cycle after `txf_space` is at or above the effective transmit level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 4 | [3:2] transmit pair select, [1:0] receive matching select |
| xon1_chr | input | 8 | Resume character, pair 1 |
| xon2_chr | input | 8 | Resume character, pair 2 |
| xoff1_chr | input | 8 | Stop character, pair 1 |
| xoff2_chr | input | 8 | Stop character, pair 2 |
| rx_lvl_cfg | input | 8 | Receive trigger level setting |
| tx_lvl_cfg | input | 8 | Transmit trigger level setting |
| rx_vld | input | 1 | Deserializer byte strobe |
| rx_data | input | 8 | Deserializer byte |
| rxf_wr_en | output | 1 | Write strobe to the receive queue |
| rxf_wr_data | output | 8 | Byte written to the receive queue |
| rxf_count | input | 8 | Current receive queue fill |
| txf_space | input | 8 | Current free space in the transmit queue |
| txq_valid | input | 1 | Transmit queue holds a byte |
| txq_data | input | 8 | Head byte of the transmit queue |
| txq_pop | output | 1 | Removes the head byte of the transmit queue |
| ser_ready | input | 1 | Serializer idle and able to take a byte |
| ser_load | output | 1 | Hands `ser_data` to the serializer |
| ser_data | output | 8 | Byte for the serializer |
| tx_pause | output | 1 | Remote side asked for transmission to stop |
| rx_irq | output | 1 | Receive trigger interrupt request |
| rx_dma | output | 1 | Receive trigger DMA request |
| tx_irq | output | 1 | Transmit trigger interrupt request |
| tx_dma | output | 1 | Transmit trigger DMA request |

## Verification
A matcher stuck in a hold state swallows the next ordinary byte, or puts a byte out of order. This shows on `rxf_wr_en`/`rxf_wr_data` within one or two cycles of the next `rx_vld`. A pause machine in the wrong state shows on `tx_pause` within three cycles of the controlling character, and as queued bytes that do or do not appear at `ser_load`. If the transmit path's record of whether a stop was sent is wrong, flow characters are duplicated or missing. That appears at `ser_load` as soon as the serializer is next idle after `rxf_count` moves.

// File: rtl/swfc_pkg.sv
package swfc_pkg;

    typedef enum logic [1:0] {
        M_IDLE,
        M_HOLD_ON,
        M_HOLD_OFF,
        M_FLUSH
    } match_st_t;

    typedef enum logic [1:0] {
        P_RUN,
        P_DRAIN,
        P_HOLD
    } pause_st_t;

    typedef enum logic {
        T_DATA,
        T_SECOND
    } tx_st_t;

endpackage

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
    import swfc_pkg::*;
#(
    parameter int CHR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rx_mode,
    input  logic             seq_en,
    input  logic [CHR_W-1:0] xon1_chr,
    input  logic [CHR_W-1:0] xon2_chr,
    input  logic [CHR_W-1:0] xoff1_chr,
    input  logic [CHR_W-1:0] xoff2_chr,
    input  logic             byte_vld,
    input  logic [CHR_W-1:0] byte_in,
    output logic             wr_en,
    output logic [CHR_W-1:0] wr_data,
    output logic             xon_det,
    output logic             xoff_det
);

    match_st_t        st_q, st_d;
    logic [CHR_W-1:0] hold_q, hold_d;
    logic [CHR_W-1:0] spill_q, spill_d;
    logic             wr_d, on_d, off_d;
    logic [CHR_W-1:0] wd_d;
    logic             any_on, any_off;

    // single-byte recognition for the non-sequence modes
    always_comb begin
        any_on  = 1'b0;
        any_off = 1'b0;
        unique case (rx_mode)
            2'b10: begin
                any_on  = (byte_in == xon1_chr);
                any_off = (byte_in == xoff1_chr);
            end
            2'b01: begin
                any_on  = (byte_in == xon2_chr);
                any_off = (byte_in == xoff2_chr);
            end
            2'b11: begin
                any_on  = (byte_in == xon1_chr) || (byte_in == xon2_chr);
                any_off = (byte_in == xoff1_chr) || (byte_in == xoff2_chr);
            end
            default: ;
        endcase
    end

    always_comb begin
        st_d    = st_q;
        hold_d  = hold_q;
        spill_d = spill_q;
        wr_d    = 1'b0;
        wd_d    = byte_in;
        on_d    = 1'b0;
        off_d   = 1'b0;
        unique case (st_q)
            M_IDLE: begin
                if (byte_vld) begin
                    if (seq_en) begin
                        if (byte_in == xoff1_chr) begin
                            st_d   = M_HOLD_OFF;
                            hold_d = byte_in;
                        end else if (byte_in == xon1_chr) begin
                            st_d   = M_HOLD_ON;
                            hold_d = byte_in;
                        end else begin
                            wr_d = 1'b1;
                        end
                    end else if (any_off) begin
                        off_d = 1'b1;
                    end else if (any_on) begin
                        on_d = 1'b1;
                    end else begin
                        wr_d = 1'b1;
                    end
                end
            end
            M_HOLD_ON, M_HOLD_OFF: begin
                if (byte_vld) begin
                    if (st_q == M_HOLD_ON && byte_in == xon2_chr) begin
                        on_d = 1'b1;
                        st_d = M_IDLE;
                    end else if (st_q == M_HOLD_OFF && byte_in == xoff2_chr) begin
                        off_d = 1'b1;
                        st_d  = M_IDLE;
                    end else begin
                        wr_d    = 1'b1;
                        wd_d    = hold_q;
                        spill_d = byte_in;
                        st_d    = M_FLUSH;
                    end
                end
            end
            M_FLUSH: begin
                wr_d = 1'b1;
                wd_d = spill_q;
                st_d = M_IDLE;
            end
            default: st_d = M_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= M_IDLE;
            hold_q  <= '0;
            spill_q <= '0;
        end else begin
            st_q    <= st_d;
            hold_q  <= hold_d;
            spill_q <= spill_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en    <= 1'b0;
            wr_data  <= '0;
            xon_det  <= 1'b0;
            xoff_det <= 1'b0;
        end else begin
            wr_en    <= wr_d;
            wr_data  <= wd_d;
            xon_det  <= on_d;
            xoff_det <= off_d;
        end
    end

    // R1
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode == 2'b00 && st_q == M_IDLE && byte_vld)
        |=> (wr_en && wr_data == $past(byte_in)));

    // R5
    write_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(byte_vld) || $past(st_q == M_FLUSH)));

endmodule

// File: rtl/swfc_pause.sv
module swfc_pause
    import swfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_off,
    input  logic xon_det,
    input  logic xoff_det,
    input  logic ser_ready,
    output logic tx_pause,
    output logic data_block
);

    pause_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            P_RUN:   if (xoff_det) st_d = P_DRAIN;
            P_DRAIN: begin
                if (xon_det)        st_d = P_RUN;
                else if (ser_ready) st_d = P_HOLD;
            end
            P_HOLD:  if (xon_det) st_d = P_RUN;
            default: st_d = P_RUN;
        endcase
        if (rx_off) st_d = P_RUN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= P_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        tx_pause   = (st_q == P_HOLD);
        data_block = (st_q != P_RUN);
    end

    // R6
    hold_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_pause) |-> $past(ser_ready));

    // R6
    resume_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xon_det |=> !tx_pause);

endmodule

// File: rtl/swfc_tx_insert.sv
module swfc_tx_insert
    import swfc_pkg::*;
#(
    parameter int CHR_W = 8,
    parameter int CNT_W = 8,
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       tx_mode,
    input  logic [CHR_W-1:0] xon1_chr,
    input  logic [CHR_W-1:0] xon2_chr,
    input  logic [CHR_W-1:0] xoff1_chr,
    input  logic [CHR_W-1:0] xoff2_chr,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             data_block,
    input  logic             txq_valid,
    input  logic [CHR_W-1:0] txq_data,
    input  logic             ser_ready,
    output logic             txq_pop,
    output logic             ser_load,
    output logic [CHR_W-1:0] ser_data
);

    tx_st_t           st_q, st_d;
    logic             stop_q, stop_d;
    logic [CHR_W-1:0] sec_q, sec_d;
    logic             tx_en, use_p1, both, need_off, need_on;

    always_comb begin
        tx_en    = (tx_mode != 2'b00);
        use_p1   = tx_mode[1];
        both     = (tx_mode == 2'b11);
        need_off = tx_en && !stop_q && (int'(rx_count) >= int'(rx_level));
        need_on  = tx_en && stop_q && (int'(rx_count) < int'(rx_level >> 1));
    end

    always_comb begin
        st_d     = st_q;
        stop_d   = stop_q;
        sec_d    = sec_q;
        ser_load = 1'b0;
        ser_data = txq_data;
        txq_pop  = 1'b0;
        if (!tx_en) stop_d = 1'b0;
        unique case (st_q)
            T_DATA: begin
                if (ser_ready) begin
                    if (need_off) begin
                        ser_load = 1'b1;
                        ser_data = use_p1 ? xoff1_chr : xoff2_chr;
                        stop_d   = 1'b1;
                        if (both) begin
                            sec_d = xoff2_chr;
                            st_d  = T_SECOND;
                        end
                    end else if (need_on) begin
                        ser_load = 1'b1;
                        ser_data = use_p1 ? xon1_chr : xon2_chr;
                        stop_d   = 1'b0;
                        if (both) begin
                            sec_d = xon2_chr;
                            st_d  = T_SECOND;
                        end
                    end else if (txq_valid && !data_block) begin
                        ser_load = 1'b1;
                        txq_pop  = 1'b1;
                    end
                end
            end
            T_SECOND: begin
                if (ser_ready) begin
                    ser_load = 1'b1;
                    ser_data = sec_q;
                    st_d     = T_DATA;
                end
            end
            default: st_d = T_DATA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= T_DATA;
            stop_q <= 1'b0;
            sec_q  <= '0;
        end else begin
            st_q   <= st_d;
            stop_q <= stop_d;
            sec_q  <= sec_d;
        end
    end

    // R7
    stop_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_q) |-> $past(ser_load));

    // R7
    pair_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T_SECOND) |-> !txq_pop);

endmodule

// File: rtl/swfc_trigger.sv
module swfc_trigger #(
    parameter int CFG_W   = 8,
    parameter int CNT_W   = 8,
    parameter int MAX_LVL = 128,
    parameter int LVL_W   = $clog2(MAX_LVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] rx_cfg,
    input  logic [CFG_W-1:0] tx_cfg,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_space,
    output logic [LVL_W-1:0] rx_level,
    output logic             rx_irq,
    output logic             rx_dma,
    output logic             tx_irq,
    output logic             tx_dma
);

    localparam int NDIR = 2;

    function automatic logic [LVL_W-1:0] eff_level(input logic [CFG_W-1:0] c);
        if (int'(c) == 0)            return LVL_W'(1);
        else if (int'(c) > MAX_LVL)  return LVL_W'(MAX_LVL);
        else                         return LVL_W'(c);
    endfunction

    logic [CFG_W-1:0] cfg_a [NDIR];
    logic [CNT_W-1:0] cnt_a [NDIR];
    logic [LVL_W-1:0] lvl_a [NDIR];
    logic             req_q [NDIR];

    always_comb begin
        cfg_a[0] = rx_cfg;
        cfg_a[1] = tx_cfg;
        cnt_a[0] = rx_count;
        cnt_a[1] = tx_space;
    end

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        always_comb lvl_a[g] = eff_level(cfg_a[g]);
        always_ff @(posedge clk) begin
            if (!rst_n) req_q[g] <= 1'b0;
            else        req_q[g] <= (int'(cnt_a[g]) >= int'(lvl_a[g]));
        end
    end

    always_comb begin
        rx_level = lvl_a[0];
        rx_irq   = req_q[0];
        rx_dma   = req_q[0];
        tx_irq   = req_q[1];
        tx_dma   = req_q[1];
    end

endmodule

// File: rtl/swfc_ctrl.sv
module swfc_ctrl #(
    parameter int CHR_W   = 8,
    parameter int CFG_W   = 8,
    parameter int CNT_W   = 8,
    parameter int MAX_LVL = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode,
    input  logic [CHR_W-1:0] xon1_chr,
    input  logic [CHR_W-1:0] xon2_chr,
    input  logic [CHR_W-1:0] xoff1_chr,
    input  logic [CHR_W-1:0] xoff2_chr,
    input  logic [CFG_W-1:0] rx_lvl_cfg,
    input  logic [CFG_W-1:0] tx_lvl_cfg,
    input  logic             rx_vld,
    input  logic [CHR_W-1:0] rx_data,
    output logic             rxf_wr_en,
    output logic [CHR_W-1:0] rxf_wr_data,
    input  logic [CNT_W-1:0] rxf_count,
    input  logic [CNT_W-1:0] txf_space,
    input  logic             txq_valid,
    input  logic [CHR_W-1:0] txq_data,
    output logic             txq_pop,
    input  logic             ser_ready,
    output logic             ser_load,
    output logic [CHR_W-1:0] ser_data,
    output logic             tx_pause,
    output logic             rx_irq,
    output logic             rx_dma,
    output logic             tx_irq,
    output logic             tx_dma
);

    localparam int LVL_W = $clog2(MAX_LVL + 1);

    logic [1:0]       tx_mode, rx_mode;
    logic             seq_en, rx_off;
    logic             xon_det, xoff_det, data_block;
    logic [LVL_W-1:0] rx_level;

    always_comb begin
        tx_mode = mode[3:2];
        rx_mode = mode[1:0];
        seq_en  = (mode == 4'b1111);
        rx_off  = (rx_mode == 2'b00);
    end

    swfc_rx_match #(.CHR_W(CHR_W)) u_match (
        .clk, .rst_n,
        .rx_mode, .seq_en,
        .xon1_chr, .xon2_chr, .xoff1_chr, .xoff2_chr,
        .byte_vld (rx_vld),
        .byte_in  (rx_data),
        .wr_en    (rxf_wr_en),
        .wr_data  (rxf_wr_data),
        .xon_det, .xoff_det
    );

    swfc_pause u_pause (
        .clk, .rst_n,
        .rx_off, .xon_det, .xoff_det, .ser_ready,
        .tx_pause, .data_block
    );

    swfc_tx_insert #(.CHR_W(CHR_W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_tx (
        .clk, .rst_n,
        .tx_mode,
        .xon1_chr, .xon2_chr, .xoff1_chr, .xoff2_chr,
        .rx_count (rxf_count),
        .rx_level,
        .data_block,
        .txq_valid, .txq_data, .ser_ready,
        .txq_pop, .ser_load, .ser_data
    );

    swfc_trigger #(.CFG_W(CFG_W), .CNT_W(CNT_W), .MAX_LVL(MAX_LVL), .LVL_W(LVL_W)) u_trig (
        .clk, .rst_n,
        .rx_cfg   (rx_lvl_cfg),
        .tx_cfg   (tx_lvl_cfg),
        .rx_count (rxf_count),
        .tx_space (txf_space),
        .rx_level,
        .rx_irq, .rx_dma, .tx_irq, .tx_dma
    );

    // R6
    paused_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pause |-> !txq_pop);

endmodule

// File: tb/swfc_ctrl_test.sv
module swfc_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int SER_CYC    = 4;
    localparam int WD_CYCLES  = 150000;
    localparam logic [7:0] XON1 = 8'h11, XON2 = 8'h12, XOFF1 = 8'h13, XOFF2 = 8'h14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode = 4'b0000;
    logic [7:0] rx_lvl_cfg = 8'd8, tx_lvl_cfg = 8'd8;
    logic       rx_vld = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rxf_wr_en;
    logic [7:0] rxf_wr_data;
    logic [7:0] rxf_count = 8'd0, txf_space = 8'd0;
    logic       txq_valid;
    logic [7:0] txq_data;
    logic       txq_pop;
    logic       ser_ready;
    logic       ser_load;
    logic [7:0] ser_data;
    logic       tx_pause, rx_irq, rx_dma, tx_irq, tx_dma;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    swfc_ctrl uut (
        .clk, .rst_n, .mode,
        .xon1_chr (XON1), .xon2_chr (XON2), .xoff1_chr (XOFF1), .xoff2_chr (XOFF2),
        .rx_lvl_cfg, .tx_lvl_cfg,
        .rx_vld, .rx_data, .rxf_wr_en, .rxf_wr_data,
        .rxf_count, .txf_space,
        .txq_valid, .txq_data, .txq_pop,
        .ser_ready, .ser_load, .ser_data,
        .tx_pause, .rx_irq, .rx_dma, .tx_irq, .tx_dma
    );

    // transmit queue and serializer models
    logic [7:0] q [64];
    logic [5:0] q_wr = '0;
    logic [5:0] q_rd;
    int         busy;
    assign txq_valid = (q_rd != q_wr);
    assign txq_data  = q[q_rd];

    always @(posedge clk) begin
        if (!rst_n) begin
            q_rd      <= '0;
            ser_ready <= 1'b1;
            busy      <= 0;
        end else begin
            if (ser_load) begin
                ser_ready <= 1'b0;
                busy      <= SER_CYC;
            end else if (!ser_ready) begin
                if (busy == 1) ser_ready <= 1'b1;
                busy <= busy - 1;
            end
            if (txq_pop) q_rd <= q_rd + 6'd1;
        end
    end

    // output logs
    logic [7:0] lg [256];
    logic [7:0] wl [256];
    int lg_n = 0;
    int wl_n = 0;
    always @(negedge clk) begin
        if (rst_n && ser_load) begin
            lg[lg_n % 256] = ser_data;
            lg_n++;
        end
        if (rst_n && rxf_wr_en) begin
            wl[wl_n % 256] = rxf_wr_data;
            wl_n++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        @(posedge clk); #1;
        rx_vld  = 1'b1;
        rx_data = b;
        @(posedge clk); #1;
        rx_vld = 1'b0;
        cyc(gap);
    endtask

    task automatic push(input logic [7:0] b);
        q[q_wr] = b;
        q_wr    = q_wr + 6'd1;
    endtask

    task automatic chk_pause(input string req, input int exp);
        @(negedge clk);
        chk(req, "tx_pause", int'(tx_pause), exp);
    endtask

    task automatic chk_seq(input string req, input string what, input bit use_lg, input int base,
                           input int n, input logic [7:0] e0, input logic [7:0] e1,
                           input logic [7:0] e2, input logic [7:0] e3);
        logic [7:0] e [4];
        int got;
        e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
        got = (use_lg ? lg_n : wl_n) - base;
        chk(req, {what, " count"}, got, n);
        for (int i = 0; i < n && i < got && i < 4; i++)
            chk(req, what, int'(use_lg ? lg[(base + i) % 256] : wl[(base + i) % 256]), int'(e[i]));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R6", "reset tx_pause", int'(tx_pause), 0);
        chk("R1", "reset rxf_wr_en", int'(rxf_wr_en), 0);
        chk("R9", "reset ser_load", int'(ser_load), 0);
        chk("R11", "reset rx_irq", int'(rx_irq), 0);
        chk("R11", "reset tx_irq", int'(tx_irq), 0);
    endtask

    task automatic t_passthru;
        int b = wl_n;
        mode = 4'b0000;
        send_byte(XON1, 3); send_byte(XOFF1, 3); send_byte(8'h55, 3);
        chk_seq("R1", "writes", 1'b0, b, 3, XON1, XOFF1, 8'h55, 8'h00);
        chk_pause("R1", 0);
    endtask

    task automatic t_pair1;
        int b = wl_n;
        mode = 4'b0010;
        send_byte(XON2, 3); send_byte(XOFF1, 3);
        chk_pause("R2", 1);
        send_byte(XOFF2, 3); send_byte(XON1, 3);
        chk_pause("R2", 0);
        chk_seq("R2", "pair1 writes", 1'b0, b, 2, XON2, XOFF2, 8'h00, 8'h00);
    endtask

    task automatic t_pair2;
        int b = wl_n;
        mode = 4'b0001;
        send_byte(XON1, 3); send_byte(XOFF2, 3);
        chk_pause("R2", 1);
        send_byte(XOFF1, 3); send_byte(XON2, 3);
        chk_pause("R2", 0);
        chk_seq("R2", "pair2 writes", 1'b0, b, 2, XON1, XOFF1, 8'h00, 8'h00);
    endtask

    task automatic t_either;
        for (int m = 0; m < 2; m++) begin
            int b  = wl_n;
            int lb = lg_n;
            mode = (m == 0) ? 4'b1011 : 4'b0111;
            send_byte(XOFF2, 3); chk_pause("R3", 1);
            send_byte(XON1, 3);  chk_pause("R3", 0);
            send_byte(XOFF1, 3); chk_pause("R3", 1);
            send_byte(XON2, 3);  chk_pause("R3", 0);
            chk_seq("R3", "either writes", 1'b0, b, 0, 8'h00, 8'h00, 8'h00, 8'h00);
            chk_seq("R3", "either loads", 1'b1, lb, 0, 8'h00, 8'h00, 8'h00, 8'h00);
        end
    endtask

    task automatic t_seq;
        int b = wl_n;
        mode = 4'b1111;
        send_byte(XOFF1, 3);
        chk_pause("R4", 0);
        send_byte(XOFF2, 3);
        chk_pause("R4", 1);
        send_byte(XON1, 3); send_byte(XON2, 3);
        chk_pause("R4", 0);
        chk_seq("R4", "seq writes", 1'b0, b, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_mismatch;
        int b = wl_n;
        mode = 4'b1111;
        send_byte(XON1, 3); send_byte(8'h41, 3);
        send_byte(XOFF1, 3); send_byte(XON1, 3);
        chk_seq("R5", "broken writes", 1'b0, b, 4, XON1, 8'h41, XOFF1, XON1);
        chk_pause("R5", 0);
        send_byte(XOFF1, 3); send_byte(XOFF2, 3);
        chk_pause("R5", 1);
        send_byte(XON1, 3); send_byte(XON2, 3);
        chk_pause("R5", 0);
        chk_seq("R5", "writes after recovery", 1'b0, b, 4, XON1, 8'h41, XOFF1, XON1);
    endtask

    task automatic t_b2b;
        int b = wl_n;
        mode = 4'b0011;
        send_byte(XOFF1, 3); chk_pause("R6", 1);
        send_byte(XOFF2, 3); chk_pause("R6", 1);
        send_byte(XOFF1, 3); chk_pause("R6", 1);
        send_byte(XON1, 3);  chk_pause("R6", 0);
        send_byte(XON2, 3);  chk_pause("R6", 0);
        send_byte(XOFF1, 1); send_byte(XON2, 4);
        chk_pause("R6", 0);
        send_byte(XOFF2, 3); chk_pause("R6", 1);
        mode = 4'b0000;
        cyc(2);
        chk_pause("R6", 0);
        chk_seq("R6", "b2b writes", 1'b0, b, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_block;
        int lb;
        mode = 4'b0010;
        send_byte(XOFF1, 3);
        lb = lg_n;
        push(8'hA1); push(8'hA2);
        cyc(30);
        chk_seq("R6", "loads while paused", 1'b1, lb, 0, 8'h00, 8'h00, 8'h00, 8'h00);
        send_byte(XON1, 3);
        cyc(30);
        chk_seq("R6", "loads after resume", 1'b1, lb, 2, 8'hA1, 8'hA2, 8'h00, 8'h00);
    endtask

    task automatic t_emit;
        logic [7:0] f1 [4];
        logic [7:0] f2 [4];
        logic [7:0] n1 [4];
        logic [7:0] n2 [4];
        int         cnt [4];
        f1[0] = 8'h00; f2[0] = 8'h00; n1[0] = 8'h00; n2[0] = 8'h00; cnt[0] = 0;
        f1[1] = XOFF2; f2[1] = 8'h00; n1[1] = XON2;  n2[1] = 8'h00; cnt[1] = 1;
        f1[2] = XOFF1; f2[2] = 8'h00; n1[2] = XON1;  n2[2] = 8'h00; cnt[2] = 1;
        f1[3] = XOFF1; f2[3] = XOFF2; n1[3] = XON1;  n2[3] = XON2;  cnt[3] = 2;
        rx_lvl_cfg = 8'd4;
        for (int t = 3; t >= 0; t--) begin
            int lb;
            rxf_count = 8'd0;
            mode = {2'(t), 2'b00};
            cyc(10);
            lb = lg_n;
            rxf_count = 8'd4;
            cyc(30);
            chk_seq("R7", "stop chars", 1'b1, lb, cnt[t], f1[t], f2[t], 8'h00, 8'h00);
            rxf_count = 8'd3;
            cyc(20);
            chk_seq("R7", "stop sent once", 1'b1, lb, cnt[t], f1[t], f2[t], 8'h00, 8'h00);
            lb = lg_n;
            rxf_count = 8'd2;
            cyc(20);
            chk_seq("R8", "no resume at half", 1'b1, lb, 0, 8'h00, 8'h00, 8'h00, 8'h00);
            rxf_count = 8'd1;
            cyc(30);
            chk_seq("R8", "resume chars", 1'b1, lb, cnt[t], n1[t], n2[t], 8'h00, 8'h00);
            rxf_count = 8'd0;
            cyc(20);
            chk_seq("R8", "resume sent once", 1'b1, lb, cnt[t], n1[t], n2[t], 8'h00, 8'h00);
        end
    endtask

    task automatic t_priority;
        int lb;
        mode = 4'b1010;
        rx_lvl_cfg = 8'd4;
        rxf_count = 8'd0;
        cyc(10);
        send_byte(XOFF1, 3);
        lb = lg_n;
        push(8'hB1);
        rxf_count = 8'd4;
        cyc(30);
        chk_seq("R9", "stop while paused", 1'b1, lb, 1, XOFF1, 8'h00, 8'h00, 8'h00);
        rxf_count = 8'd0;
        cyc(30);
        chk_seq("R9", "resume while paused", 1'b1, lb, 2, XOFF1, XON1, 8'h00, 8'h00);
        send_byte(XON1, 3);
        cyc(30);
        chk_seq("R9", "data after resume", 1'b1, lb, 3, XOFF1, XON1, 8'hB1, 8'h00);
        lb = lg_n;
        rxf_count = 8'd4;
        push(8'hB2); push(8'hB3);
        cyc(40);
        chk_seq("R9", "stop before data", 1'b1, lb, 3, XOFF1, 8'hB2, 8'hB3, 8'h00);
        rxf_count = 8'd0;
        cyc(30);
        chk_seq("R9", "final resume", 1'b1, lb, 4, XOFF1, 8'hB2, 8'hB3, XON1);
    endtask

    task automatic lvl_case(input logic [7:0] rcfg, input logic [7:0] rcnt, input int rexp,
                            input logic [7:0] tcfg, input logic [7:0] tsp, input int texp);
        rx_lvl_cfg = rcfg; rxf_count = rcnt;
        tx_lvl_cfg = tcfg; txf_space = tsp;
        cyc(2);
        @(negedge clk);
        chk("R10", "rx_irq", int'(rx_irq), rexp);
        chk("R11", "rx_dma", int'(rx_dma), rexp);
        chk("R10", "tx_irq", int'(tx_irq), texp);
        chk("R11", "tx_dma", int'(tx_dma), texp);
    endtask

    task automatic t_levels;
        mode = 4'b0000;
        lvl_case(8'h00, 8'd1,   1, 8'h00, 8'd1,   1);
        lvl_case(8'h00, 8'd0,   0, 8'h00, 8'd0,   0);
        lvl_case(8'h01, 8'd1,   1, 8'h01, 8'd0,   0);
        lvl_case(8'h05, 8'd4,   0, 8'h05, 8'd5,   1);
        lvl_case(8'h05, 8'd5,   1, 8'h05, 8'd4,   0);
        lvl_case(8'h80, 8'd127, 0, 8'h80, 8'd128, 1);
        lvl_case(8'h80, 8'd128, 1, 8'h80, 8'd127, 0);
        lvl_case(8'hFF, 8'd127, 0, 8'hC0, 8'd128, 1);
        lvl_case(8'hFF, 8'd128, 1, 8'hC0, 8'd127, 0);
        rxf_count = 8'd0; txf_space = 8'd0;
    endtask

    task automatic wrap_up;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WD_CYCLES);
        wrap_up();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_passthru();
        t_pair1();
        t_pair2();
        t_either();
        t_seq();
        t_mismatch();
        t_b2b();
        t_block();
        t_emit();
        t_priority();
        t_levels();
        wrap_up();
    end

endmodule